// File: doc/BRIEF.md
# DRAM Power-Down Mode Controller

This block sits on the controller side of a DDR2-style memory channel, between the command scheduler and the memory pins. While idle it passes the scheduler's command through with a one-cycle register stage, with CKE high. When a power-down request arrives and no read burst, write burst or write recovery is in progress, it drops CKE together with a NOP. It records which flavour of power-down was entered:
- precharge, when no row is open;
- fast-exit active, when a row is open and the mode-register exit bit is low;
- slow-exit active, when a row is open and that bit is high.

On leaving, the block raises CKE together with a NOP. It then keeps the command lines at NOP for the exit latency that belongs to the recorded flavour. Only after that does it hand the command lines back to the scheduler. A command-blocked output tells the scheduler when its commands are being replaced.

A residency counter tracks how long CKE has been low. The memory must not stay down longer than a multiple of the refresh interval. For that reason the block forces an exit early enough that the exit latency also fits inside that limit. It flags the forced exit to the refresh scheduler. After a forced exit it does not re-enter until the request has been withdrawn at least once. An indicator shows when the memory's DLL is switched off, which is the case in precharge and slow-exit active power-down.

Top module: `pdn_ctrl`

## Requirements
- R1: With `pd_req` high, `rw_busy` low and re-entry allowed, the next rising edge drives `cke` low with `dram_cmd` = NOP (4'b0111, bits {cs_n, ras_n, cas_n, we_n}). `cmd_blocked` goes high in that same cycle.
- R2: While `rw_busy` is high, no entry takes place; `cke` stays high and commands keep flowing.
- R3: `pd_mode` reports the mode recorded at entry: 1 = precharge (`row_open` low), 2 = fast-exit active (`row_open` high, `mr_slow_exit` low), 3 = slow-exit active (both high). It reports 0 once the exit latency is over. Input changes while down do not alter it.
- R4: When `pd_req` is low during power-down, the next rising edge drives `cke` high with `dram_cmd` = NOP.
- R5: After `cke` rises, `dram_cmd` stays NOP and `cmd_blocked` stays high for LAT cycles. LAT is `T_XP`, `T_XARD` or `T_XARDS` for mode 1, 2 or 3 respectively. The registered host command appears in the cycle after that. LAT follows the recorded mode, not the current `mr_slow_exit`.
- R6: `cke` is low for at most 9·`T_REFI` − LAT consecutive cycles. When that count is reached, `force_exit` is high for exactly that last low cycle, and `cke` rises on the next edge.
- R7: After a forced exit, the block does not enter power-down again until `pd_req` has been sampled low at least once.
- R8: `dll_off` is high exactly while `cke` is low in mode 1 or mode 3. It is low in mode 2, during the exit latency and when idle.
- R9: While idle, `cke` is high, `cmd_blocked` is low, and `dram_cmd` equals `host_cmd` from the previous cycle.
- R10: During and after reset, `cke` is high, `dram_cmd` is NOP, and `cmd_blocked`, `dll_off`, `force_exit` and `pd_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pd_req | input | 1 | Request to be in power-down (level) |
| rw_busy | input | 1 | Read/write burst or write recovery in progress |
| row_open | input | 1 | At least one bank has an open row |
| mr_slow_exit | input | 1 | Mode-register bit: 1 selects slow exit for active power-down |
| host_cmd | input | 4 | Scheduler command {cs_n, ras_n, cas_n, we_n} |
| cke | output | 1 | Clock enable to the memory |
| dram_cmd | output | 4 | Command to the memory {cs_n, ras_n, cas_n, we_n} |
| cmd_blocked | output | 1 | Scheduler commands are being replaced by NOP |
| dll_off | output | 1 | Memory DLL is disabled in the present state |
| pd_mode | output | 2 | Recorded power-down mode (0 none) |
| force_exit | output | 1 | Residency limit forces exit on the next edge |

## Verification
The bench builds the block with `T_REFI` = 8, so the residency limit is 72 cycles. Forced exits, and the rule that blocks re-entry after them, therefore occur many times within a short run. The three exit latencies are set to distinct values (3, 2 and 6). A wrong choice of flavour shows up as a shifted release of the command lines. The wrong choice may come from the mode recorded at entry or from the live mode bit at exit; both are caught. A shift in the point at which the block forces an exit is also caught.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

  typedef enum logic [1:0] {
    PDM_NONE     = 2'd0,
    PDM_PRE      = 2'd1,
    PDM_ACT_FAST = 2'd2,
    PDM_ACT_SLOW = 2'd3
  } pdn_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DOWN = 2'd1,
    ST_WAKE = 2'd2
  } pdn_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;

endpackage

// File: rtl/pdn_entry_gate.sv
module pdn_entry_gate
  import pdn_pkg::*;
(
  input  logic      pd_req,
  input  logic      rw_busy,
  input  logic      armed,
  input  logic      row_open,
  input  logic      slow_sel,
  output logic      enter_ok,
  output pdn_mode_e sel_mode
);

  always_comb begin
    enter_ok = pd_req && !rw_busy && armed;
    if (!row_open)
      sel_mode = PDM_PRE;
    else if (slow_sel)
      sel_mode = PDM_ACT_SLOW;
    else
      sel_mode = PDM_ACT_FAST;
  end

endmodule

// File: rtl/pdn_exit_timer.sv
module pdn_exit_timer
  import pdn_pkg::*;
#(
  parameter int T_XP    = 2,
  parameter int T_XARD  = 2,
  parameter int T_XARDS = 7,
  parameter int LAT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pdn_mode_e        mode,
  input  logic             load,
  input  logic             run,
  output logic [LAT_W-1:0] lat,
  output logic             done
);

  logic [LAT_W-1:0] xcnt_q, xcnt_d;
  logic             xcnt_en;

  always_comb begin
    case (mode)
      PDM_ACT_FAST: lat = LAT_W'(T_XARD);
      PDM_ACT_SLOW: lat = LAT_W'(T_XARDS);
      default:      lat = LAT_W'(T_XP);
    endcase
  end

  always_comb begin
    xcnt_en = 1'b0;
    xcnt_d  = xcnt_q;
    if (load) begin
      xcnt_en = 1'b1;
      xcnt_d  = lat - LAT_W'(1);
    end else if (run && (xcnt_q != '0)) begin
      xcnt_en = 1'b1;
      xcnt_d  = xcnt_q - LAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      xcnt_q <= '0;
    else if (xcnt_en)
      xcnt_q <= xcnt_d;
  end

  assign done = run && (xcnt_q == '0);

  // R5: remaining wake count never reaches the full latency of the recorded mode
  p_wake_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (xcnt_q < lat));

endmodule

// File: rtl/pdn_residency.sv
module pdn_residency #(
  parameter int LIMIT = 72,
  parameter int CNT_W = 7,
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [LAT_W-1:0] lat,
  output logic             force_exit
);

  logic [CNT_W-1:0] res_q, res_d;
  logic             res_en;
  logic [CNT_W-1:0] thr;

  // last allowed low cycle index (counter starts at 0 in the first low cycle)
  assign thr = CNT_W'(LIMIT) - CNT_W'(lat) - CNT_W'(1);

  assign force_exit = run && (res_q >= thr);

  always_comb begin
    res_en = 1'b0;
    res_d  = res_q;
    if (start) begin
      res_en = 1'b1;
      res_d  = '0;
    end else if (run && !force_exit) begin
      res_en = 1'b1;
      res_d  = res_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      res_q <= '0;
    else if (res_en)
      res_q <= res_d;
  end

  // R6: the residency count never passes the forced-exit threshold
  p_res_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (res_q <= thr));

  // R6: a forced exit always ends the low period on the next edge
  p_force_leaves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    force_exit |=> !run);

endmodule

// File: rtl/pdn_ctrl.sv
module pdn_ctrl
  import pdn_pkg::*;
#(
  parameter int T_XP      = 2,
  parameter int T_XARD    = 2,
  parameter int T_XARDS   = 7,
  parameter int T_REFI    = 3120,
  parameter int REFI_MULT = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_req,
  input  logic       rw_busy,
  input  logic       row_open,
  input  logic       mr_slow_exit,
  input  logic [3:0] host_cmd,
  output logic       cke,
  output logic [3:0] dram_cmd,
  output logic       cmd_blocked,
  output logic       dll_off,
  output logic [1:0] pd_mode,
  output logic       force_exit
);

  localparam int LIMIT   = REFI_MULT * T_REFI;
  localparam int CNT_W   = $clog2(LIMIT + 1);
  localparam int MAX_A   = (T_XARD > T_XARDS) ? T_XARD : T_XARDS;
  localparam int MAX_LAT = (T_XP > MAX_A) ? T_XP : MAX_A;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  pdn_state_e       state_q, state_d;
  pdn_mode_e        mode_q, mode_d;
  logic             cke_q, cke_d;
  logic [3:0]       cmd_q, cmd_d;
  logic             blk_q, blk_d;
  logic             armed_q, armed_d;

  logic             enter_ok;
  pdn_mode_e        sel_mode;
  logic [LAT_W-1:0] lat;
  logic             wake_done;
  logic             force_w;
  logic             go_down;
  logic             go_wake;

  pdn_entry_gate u_gate (
    .pd_req   (pd_req),
    .rw_busy  (rw_busy),
    .armed    (armed_q),
    .row_open (row_open),
    .slow_sel (mr_slow_exit),
    .enter_ok (enter_ok),
    .sel_mode (sel_mode)
  );

  pdn_exit_timer #(
    .T_XP    (T_XP),
    .T_XARD  (T_XARD),
    .T_XARDS (T_XARDS),
    .LAT_W   (LAT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode_q),
    .load  (go_wake),
    .run   (state_q == ST_WAKE),
    .lat   (lat),
    .done  (wake_done)
  );

  pdn_residency #(
    .LIMIT (LIMIT),
    .CNT_W (CNT_W),
    .LAT_W (LAT_W)
  ) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (go_down),
    .run        (state_q == ST_DOWN),
    .lat        (lat),
    .force_exit (force_w)
  );

  assign go_down = (state_q == ST_IDLE) && enter_ok;
  assign go_wake = (state_q == ST_DOWN) && (force_w || !pd_req);

  // next-state process
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    cke_d   = cke_q;
    cmd_d   = CMD_NOP;
    blk_d   = blk_q;
    armed_d = armed_q;
    if (!pd_req)
      armed_d = 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (go_down) begin
          state_d = ST_DOWN;
          mode_d  = sel_mode;
          cke_d   = 1'b0;
          blk_d   = 1'b1;
        end else begin
          cmd_d   = host_cmd;
        end
      end
      ST_DOWN: begin
        if (go_wake) begin
          state_d = ST_WAKE;
          cke_d   = 1'b1;
          if (force_w)
            armed_d = 1'b0;
        end
      end
      ST_WAKE: begin
        if (wake_done) begin
          state_d = ST_IDLE;
          mode_d  = PDM_NONE;
          blk_d   = 1'b0;
          cmd_d   = host_cmd;
        end
      end
      default: begin
        state_d = ST_IDLE;
        mode_d  = PDM_NONE;
        cke_d   = 1'b1;
        blk_d   = 1'b0;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= PDM_NONE;
      cke_q   <= 1'b1;
      cmd_q   <= CMD_NOP;
      blk_q   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cke_q   <= cke_d;
      cmd_q   <= cmd_d;
      blk_q   <= blk_d;
      armed_q <= armed_d;
    end
  end

  assign cke         = cke_q;
  assign dram_cmd    = cmd_q;
  assign cmd_blocked = blk_q;
  assign pd_mode     = mode_q;
  assign force_exit  = force_w;
  assign dll_off     = (state_q == ST_DOWN) &&
                       ((mode_q == PDM_PRE) || (mode_q == PDM_ACT_SLOW));

  // R1: every CKE transition is accompanied by a NOP
  p_nop_on_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cke_q) || $rose(cke_q)) |-> (cmd_q == CMD_NOP));

  // R2: CKE only falls when no burst or recovery was in progress
  p_entry_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_q) |-> $past(!rw_busy && pd_req));

  // R3: the recorded mode is held for the whole low period
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_q && $past(!cke_q)) |-> $stable(mode_q));

  // R5: commands are blocked whenever CKE is low
  p_block_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |-> blk_q);

  // R7: a disarmed idle block keeps CKE high on the next cycle
  p_no_reentry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !armed_q) |=> cke_q);

  // R8: the DLL indication only appears while CKE is low
  p_dll_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dll_off |-> !cke_q);

endmodule

// File: tb/pdn_ctrl_test.sv
module pdn_ctrl_test;

  localparam int P_XP    = 3;
  localparam int P_XARD  = 2;
  localparam int P_XARDS = 6;
  localparam int P_REFI  = 8;
  localparam int P_LIMIT = 9 * P_REFI;
  localparam logic [3:0] NOP = 4'b0111;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pd_req, rw_busy, row_open, mr_slow_exit;
  logic [3:0] host_cmd;
  logic       cke, cmd_blocked, dll_off, force_exit;
  logic [3:0] dram_cmd;
  logic [1:0] pd_mode;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model state
  int         m_st;      // 0 idle, 1 down, 2 wake
  int         m_mode;
  int         m_low;
  int         m_hi;
  bit         m_armed;
  bit         m_cke;
  logic [3:0] m_cmd;
  bit         m_blk;

  always #10 clk = ~clk;

  pdn_ctrl #(
    .T_XP      (P_XP),
    .T_XARD    (P_XARD),
    .T_XARDS   (P_XARDS),
    .T_REFI    (P_REFI),
    .REFI_MULT (9)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pd_req       (pd_req),
    .rw_busy      (rw_busy),
    .row_open     (row_open),
    .mr_slow_exit (mr_slow_exit),
    .host_cmd     (host_cmd),
    .cke          (cke),
    .dram_cmd     (dram_cmd),
    .cmd_blocked  (cmd_blocked),
    .dll_off      (dll_off),
    .pd_mode      (pd_mode),
    .force_exit   (force_exit)
  );

  function automatic int lat_of(input int mode);
    if (mode == 2) return P_XARD;
    if (mode == 3) return P_XARDS;
    return P_XP;
  endfunction

  function automatic bit exp_force();
    return (m_st == 1) && (m_low == P_LIMIT - lat_of(m_mode));
  endfunction

  function automatic bit exp_dll();
    return (m_st == 1) && (m_mode == 1 || m_mode == 3);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    check(cke === m_cke, "R1/R4 cke", int'(cke), int'(m_cke));
    check(dram_cmd === m_cmd, "R5/R9 dram_cmd", int'(dram_cmd), int'(m_cmd));
    check(cmd_blocked === m_blk, "R5 cmd_blocked", int'(cmd_blocked), int'(m_blk));
    check(pd_mode === 2'(m_mode), "R3 pd_mode", int'(pd_mode), m_mode);
    check(dll_off === exp_dll(), "R8 dll_off", int'(dll_off), int'(exp_dll()));
    check(force_exit === exp_force(), "R6 force_exit", int'(force_exit), int'(exp_force()));
  endtask

  // advance the model by one rising edge using the inputs now applied
  task automatic model_step();
    bit f;
    f = exp_force();
    case (m_st)
      0: begin
        if (pd_req && !rw_busy && m_armed) begin
          m_st = 1; m_cke = 1'b0; m_cmd = NOP; m_blk = 1'b1; m_low = 1;
          m_mode = !row_open ? 1 : (mr_slow_exit ? 3 : 2);
        end else begin
          m_cmd = host_cmd;
        end
        if (!pd_req) m_armed = 1'b1;
      end
      1: begin
        m_cmd = NOP;
        if (!pd_req) m_armed = 1'b1;
        if (f || !pd_req) begin
          m_st = 2; m_cke = 1'b1; m_hi = 1;
          if (f) m_armed = 1'b0;
        end else begin
          m_low++;
        end
      end
      default: begin
        if (!pd_req) m_armed = 1'b1;
        if (m_hi == lat_of(m_mode)) begin
          m_st = 0; m_blk = 1'b0; m_cmd = host_cmd; m_mode = 0;
        end else begin
          m_cmd = NOP; m_hi++;
        end
      end
    endcase
  endtask

  task automatic tick(input bit req, input bit busy, input bit row,
                      input bit slow, input logic [3:0] hc);
    pd_req = req; rw_busy = busy; row_open = row; mr_slow_exit = slow; host_cmd = hc;
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    rst_n = 1'b0;
    pd_req = 1'b0; rw_busy = 1'b0; row_open = 1'b0; mr_slow_exit = 1'b0;
    host_cmd = 4'b0000;
    m_st = 0; m_mode = 0; m_low = 0; m_hi = 0; m_armed = 1'b1;
    m_cke = 1'b1; m_cmd = NOP; m_blk = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset values
    check(cke === 1'b1 && dram_cmd === NOP && cmd_blocked === 1'b0 &&
          dll_off === 1'b0 && force_exit === 1'b0 && pd_mode === 2'd0,
          "R10 reset state", int'({cke, dram_cmd, cmd_blocked, dll_off, force_exit, pd_mode}),
          int'({1'b1, NOP, 5'b0}));
    rst_n = 1'b1;
    compare_all();

    // R9: idle pass-through
    tick(0, 0, 0, 0, 4'b0011);
    check(dram_cmd === 4'b0011, "R9 idle forward", int'(dram_cmd), 3);

    // R2: entry deferred while busy
    for (int i = 0; i < 4; i++) tick(1, 1, 0, 0, NOP);
    check(cke === 1'b1, "R2 busy holds cke", int'(cke), 1);
    // R1: entry into precharge power-down
    tick(1, 0, 0, 0, NOP);
    check(cke === 1'b0 && cmd_blocked === 1'b1, "R1 entry", int'(cke), 0);
    check(pd_mode === 2'd1, "R3 precharge mode", int'(pd_mode), 1);
    tick(1, 0, 1, 1, NOP);
    // R4: exit on request drop
    tick(0, 0, 1, 1, 4'b0101);
    check(cke === 1'b1 && dram_cmd === NOP, "R4 exit", int'(cke), 1);
    for (int i = 0; i < P_XP - 1; i++) tick(0, 0, 0, 0, 4'b0101);
    check(cmd_blocked === 1'b1, "R5 still blocked", int'(cmd_blocked), 1);
    tick(0, 0, 0, 0, 4'b0101);
    check(dram_cmd === 4'b0101 && cmd_blocked === 1'b0, "R5 release after tXP",
          int'(dram_cmd), 5);

    // R5: slow mode recorded, bit flipped while down must not matter
    tick(1, 0, 1, 1, NOP);
    check(pd_mode === 2'd3 && dll_off === 1'b1, "R8 slow mode dll off", int'(pd_mode), 3);
    tick(1, 0, 1, 0, NOP);
    tick(0, 0, 1, 0, 4'b0001);
    for (int i = 0; i < P_XARDS; i++) tick(0, 0, 1, 0, 4'b0001);
    check(dram_cmd === 4'b0001, "R5 slow latency from recorded mode", int'(dram_cmd), 1);

    // R8: fast active keeps DLL on
    tick(1, 0, 1, 0, NOP);
    check(pd_mode === 2'd2 && dll_off === 1'b0, "R8 fast mode dll on", int'(dll_off), 0);

    // R6/R7: hold request until forced exit, then verify no re-entry
    while (m_st == 1) tick(1, 0, 1, 1, NOP);
    for (int i = 0; i < 12; i++) tick(1, 0, 0, 0, NOP);
    check(cke === 1'b1, "R7 no re-entry after forced exit", int'(cke), 1);
    tick(0, 0, 0, 0, NOP);
    tick(1, 0, 0, 0, NOP);
    check(cke === 1'b0, "R7 re-entry after withdrawal", int'(cke), 0);
    // forced exit from precharge mode
    while (m_st == 1) tick(1, 0, 0, 0, NOP);
    tick(0, 0, 0, 0, NOP);

    // random phase
    begin
      bit req = 1'b0;
      int run_len = 0;
      for (int c = 0; c < 6000; c++) begin
        if (run_len == 0) begin
          req = ~req;
          run_len = 1 + int'($urandom % (req ? 110 : 20));
        end
        run_len--;
        tick(req, ($urandom % 4) == 0, $urandom % 2, $urandom % 2, 4'($urandom));
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule